// File: doc/BRIEF.md
# Multiplexed-Address DRAM Controller

This controller turns simple word requests into the strobe sequence of a DRAM whose row and column addresses share one 11-bit address bus. A request carries a 22-bit word address, a read/write flag and a burst length. The controller opens the row by driving the upper address half with the row strobe. After a programmable row-to-column delay it drives successive column addresses with the column strobe, one 4-bit word per cycle. The column advances by one on every beat and stays inside the open row. After the burst all strobes return high for a programmable precharge time.

An interval counter raises refresh requests by itself. Each request refreshes one row with a row-strobe-only activation, and the row counter steps through all 2048 rows in order before it starts again. A pending refresh is served only while the controller is idle, ahead of any waiting request, so a burst is never split. The request port uses a valid/ready handshake. The memory data bus is split on the chip side into an output, an output enable and an input, ready to meet a bidirectional pad.

Top module: `dram_mux_ctrl`

## Requirements
- R1: While reset is held and in the first idle cycle after it, `mem_ras_no`, `mem_cas_no`, `mem_we_no` and `mem_oe_no` are high, `req_ready_o` is high and `rdata_valid_o` is low.
- R2: In the cycle after a request is accepted (`req_valid_i` and `req_ready_o` high at a clock edge), `mem_ras_no` is low and `mem_cas_no` is high for exactly T_RCD cycles. During those cycles `mem_addr_o` holds the row, `req_addr_i[21:11]`, and does not change.
- R3: The row phase is followed at once by `req_len_i`+1 consecutive column cycles with `mem_ras_no` and `mem_cas_no` both low. Beat k drives column `(req_addr_i[10:0] + k) mod 2048`, so the column wraps from 2047 to 0 inside the same open row, and no refresh or other access interrupts the burst.
- R4: During read beats `mem_oe_no` is low, `mem_we_no` is high and `mem_dq_oe_o` is low. One cycle after each read beat, `rdata_valid_o` is high and `rdata_o` holds the value that was on `mem_dq_i` in that beat.
- R5: During write beats `mem_we_no` is low, `mem_oe_no` is high, `mem_dq_oe_o` and `wdata_ready_o` are high, and `mem_dq_o` equals `wdata_i`. The word is stored at the column of that beat.
- R6: After each activation, whether a burst or a refresh, all four strobes stay high for at least T_RP cycles before the next row strobe. `req_ready_o` is high only while the controller is idle with no refresh pending.
- R7: A refresh request arises every REF_INTERVAL cycles. Each one produces a single activation with `mem_ras_no` low and `mem_cas_no` high for T_RCD cycles. Refreshed rows run 0, 1, 2, … and wrap from 2047 to 0.
- R8: A pending refresh drops `req_ready_o` and is served before a request that is already waiting. It starts only between accesses.
- R9: `mem_cas_no` is low only while `mem_ras_no` is low, and `mem_we_no` and `mem_oe_no` are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request accepted at this edge when valid |
| req_we_i | input | 1 | 1 = write burst, 0 = read burst |
| req_addr_i | input | 22 | Word address, row in [21:11], column in [10:0] |
| req_len_i | input | 3 | Burst length minus one |
| wdata_i | input | 4 | Write word for the current beat |
| wdata_ready_o | output | 1 | High in each write beat; `wdata_i` is taken |
| rdata_o | output | 4 | Read word |
| rdata_valid_o | output | 1 | `rdata_o` valid |
| mem_addr_o | output | 11 | Multiplexed row/column address |
| mem_ras_no | output | 1 | Row strobe, active low |
| mem_cas_no | output | 1 | Column strobe, active low |
| mem_we_no | output | 1 | Write enable, active low |
| mem_oe_no | output | 1 | Output enable, active low |
| mem_dq_o | output | 4 | Data toward the memory |
| mem_dq_oe_o | output | 1 | Drive enable for `mem_dq_o` onto the shared data pins |
| mem_dq_i | input | 4 | Data from the memory |

## Verification
The bench builds the controller with T_RCD = 2, T_RP = 2, a 3-bit burst length and REF_INTERVAL = 16. The short refresh interval lets refresh ticks fall inside the 13-cycle longest burst, so the rule against splitting a burst gets tested many times. It also brings the row counter's wrap from 2047 to 0 within about 33,000 cycles. The two-cycle delays make the row and precharge windows long enough to check that the address holds steady and that the gap between activations is kept.

// File: rtl/dram_mux_pkg.sv
package dram_mux_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ROW,
    ST_COL,
    ST_PRE,
    ST_REF
  } seq_state_e;
endpackage

// File: rtl/dram_ref_timer.sv
module dram_ref_timer #(
  parameter int unsigned INTERVAL = 780,
  parameter int unsigned ROW_W    = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ack_i,
  input  logic             done_i,
  output logic             pend_o,
  output logic [ROW_W-1:0] row_o
);
  localparam int unsigned CNT_W = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(INTERVAL - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             tick;

  assign tick = (cnt_q == CNT_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      pend_o <= 1'b0;
      row_o  <= '0;
    end else begin
      cnt_q <= tick ? '0 : cnt_q + CNT_W'(1);
      // a new tick wins over a same-cycle acknowledge
      if (tick)       pend_o <= 1'b1;
      else if (ack_i) pend_o <= 1'b0;
      if (done_i)     row_o  <= row_o + ROW_W'(1);
    end
  end
endmodule

// File: rtl/dram_burst_col.sv
module dram_burst_col #(
  parameter int unsigned COL_W = 11,
  parameter int unsigned LEN_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [COL_W-1:0] col_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             step_i,
  output logic [COL_W-1:0] col_o,
  output logic             last_o
);
  logic [LEN_W-1:0] left_q;

  assign last_o = (left_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      col_o  <= '0;
      left_q <= '0;
    end else if (load_i) begin
      col_o  <= col_i;
      left_q <= len_i;
    end else if (step_i) begin
      col_o  <= col_o + COL_W'(1);  // wraps inside the open row
      left_q <= left_q - LEN_W'(1);
    end
  end
endmodule

// File: rtl/dram_seq_fsm.sv
module dram_seq_fsm
  import dram_mux_pkg::*;
#(
  parameter int unsigned T_RCD = 2,
  parameter int unsigned T_RP  = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_valid_i,
  input  logic       ref_pend_i,
  input  logic       last_beat_i,
  output seq_state_e state_o,
  output logic       ready_o,
  output logic       accept_o,
  output logic       ref_ack_o,
  output logic       ref_done_o
);
  localparam int unsigned T_MAX = (T_RCD > T_RP) ? T_RCD : T_RP;
  localparam int unsigned TW    = $clog2(T_MAX + 1);
  localparam logic [TW-1:0] RCD_LD = TW'(T_RCD - 1);
  localparam logic [TW-1:0] RP_LD  = TW'(T_RP - 1);

  logic [TW-1:0] tmr_q;
  logic          tmr_zero;

  assign tmr_zero   = (tmr_q == '0);
  assign ready_o    = (state_o == ST_IDLE) && !ref_pend_i;
  assign accept_o   = ready_o && req_valid_i;
  assign ref_ack_o  = (state_o == ST_IDLE) && ref_pend_i;
  assign ref_done_o = (state_o == ST_REF) && tmr_zero;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_o <= ST_IDLE;
      tmr_q   <= '0;
    end else begin
      unique case (state_o)
        ST_IDLE: begin
          if (ref_pend_i) begin
            state_o <= ST_REF;
            tmr_q   <= RCD_LD;
          end else if (req_valid_i) begin
            state_o <= ST_ROW;
            tmr_q   <= RCD_LD;
          end
        end
        ST_ROW: begin
          if (tmr_zero) state_o <= ST_COL;
          else          tmr_q   <= tmr_q - TW'(1);
        end
        ST_COL: begin
          if (last_beat_i) begin
            state_o <= ST_PRE;
            tmr_q   <= RP_LD;
          end
        end
        ST_REF: begin
          if (tmr_zero) begin
            state_o <= ST_PRE;
            tmr_q   <= RP_LD;
          end else begin
            tmr_q <= tmr_q - TW'(1);
          end
        end
        ST_PRE: begin
          if (tmr_zero) state_o <= ST_IDLE;
          else          tmr_q   <= tmr_q - TW'(1);
        end
        default: state_o <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dram_mux_ctrl.sv
module dram_mux_ctrl
  import dram_mux_pkg::*;
#(
  parameter int unsigned ROW_W        = 11,
  parameter int unsigned COL_W        = 11,
  parameter int unsigned DQ_W         = 4,
  parameter int unsigned LEN_W        = 3,
  parameter int unsigned T_RCD        = 2,
  parameter int unsigned T_RP         = 2,
  parameter int unsigned REF_INTERVAL = 780,
  localparam int unsigned ADDR_W      = ROW_W + COL_W,
  localparam int unsigned BUS_W       = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_we_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [LEN_W-1:0]  req_len_i,
  input  logic [DQ_W-1:0]   wdata_i,
  output logic              wdata_ready_o,
  output logic [DQ_W-1:0]   rdata_o,
  output logic              rdata_valid_o,
  output logic [BUS_W-1:0]  mem_addr_o,
  output logic              mem_ras_no,
  output logic              mem_cas_no,
  output logic              mem_we_no,
  output logic              mem_oe_no,
  output logic [DQ_W-1:0]   mem_dq_o,
  output logic              mem_dq_oe_o,
  input  logic [DQ_W-1:0]   mem_dq_i
);
  seq_state_e       state;
  logic             accept, ref_ack, ref_done, ref_pend, last_beat;
  logic [ROW_W-1:0] row_q, ref_row;
  logic [COL_W-1:0] col_cur;
  logic             we_q;
  logic             in_col, wr_beat, rd_beat;

  dram_ref_timer #(.INTERVAL(REF_INTERVAL), .ROW_W(ROW_W)) u_ref (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ack_i  (ref_ack),
    .done_i (ref_done),
    .pend_o (ref_pend),
    .row_o  (ref_row)
  );

  dram_seq_fsm #(.T_RCD(T_RCD), .T_RP(T_RP)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .ref_pend_i  (ref_pend),
    .last_beat_i (last_beat),
    .state_o     (state),
    .ready_o     (req_ready_o),
    .accept_o    (accept),
    .ref_ack_o   (ref_ack),
    .ref_done_o  (ref_done)
  );

  dram_burst_col #(.COL_W(COL_W), .LEN_W(LEN_W)) u_col (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (accept),
    .col_i  (req_addr_i[COL_W-1:0]),
    .len_i  (req_len_i),
    .step_i (in_col),
    .col_o  (col_cur),
    .last_o (last_beat)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_q <= '0;
      we_q  <= 1'b0;
    end else if (accept) begin
      row_q <= req_addr_i[ADDR_W-1:COL_W];
      we_q  <= req_we_i;
    end
  end

  assign in_col  = (state == ST_COL);
  assign wr_beat = in_col && we_q;
  assign rd_beat = in_col && !we_q;

  always_comb begin
    unique case (state)
      ST_ROW:  mem_addr_o = BUS_W'(row_q);
      ST_REF:  mem_addr_o = BUS_W'(ref_row);
      ST_COL:  mem_addr_o = BUS_W'(col_cur);
      default: mem_addr_o = '0;
    endcase
  end

  assign mem_ras_no    = !((state == ST_ROW) || (state == ST_COL) || (state == ST_REF));
  assign mem_cas_no    = !in_col;
  assign mem_we_no     = !wr_beat;
  assign mem_oe_no     = !rd_beat;
  assign mem_dq_o      = wdata_i;
  assign mem_dq_oe_o   = wr_beat;
  assign wdata_ready_o = wr_beat;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o       <= '0;
      rdata_valid_o <= 1'b0;
    end else begin
      rdata_valid_o <= rd_beat;
      if (rd_beat) rdata_o <= mem_dq_i;
    end
  end
endmodule

module dram_mux_ctrl_chk #(
  parameter int unsigned BUS_W = 11
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_ready_o,
  input logic             rdata_valid_o,
  input logic [BUS_W-1:0] mem_addr_o,
  input logic             mem_ras_no,
  input logic             mem_cas_no,
  input logic             mem_we_no,
  input logic             mem_oe_no,
  input logic             mem_dq_oe_o
);
  // R9
  cas_in_row_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_cas_no |-> !mem_ras_no);
  // R9
  oe_we_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!mem_oe_no && !mem_we_no));
  // R5
  dq_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_dq_oe_o |-> (!mem_we_no && !mem_cas_no));
  // R6
  ready_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (mem_ras_no && mem_cas_no));
  // R3
  col_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_cas_no && $past(!mem_cas_no)) |-> (mem_addr_o == BUS_W'($past(mem_addr_o) + 1'b1)));
  // R4
  rvalid_after_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_valid_o |-> $past(!mem_cas_no && !mem_oe_no));
  // R2
  row_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_ras_no && mem_cas_no && $past(!mem_ras_no && mem_cas_no)) |-> $stable(mem_addr_o));
endmodule

bind dram_mux_ctrl dram_mux_ctrl_chk #(.BUS_W(BUS_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .req_ready_o   (req_ready_o),
  .rdata_valid_o (rdata_valid_o),
  .mem_addr_o    (mem_addr_o),
  .mem_ras_no    (mem_ras_no),
  .mem_cas_no    (mem_cas_no),
  .mem_we_no     (mem_we_no),
  .mem_oe_no     (mem_oe_no),
  .mem_dq_oe_o   (mem_dq_oe_o)
);

// File: tb/tb_dram_mux_ctrl.sv
module tb_dram_mux_ctrl;
  localparam int CLK_PERIOD   = 10;
  localparam int T_RCD        = 2;
  localparam int T_RP         = 2;
  localparam int REF_INTERVAL = 16;
  localparam int NVEC         = 10;
  localparam int LONG_IDLE    = 2048 * REF_INTERVAL + 64;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready, req_we;
  logic [21:0] req_addr;
  logic [2:0]  req_len;
  logic [3:0]  wdata, rdata, dq_o, dq_i;
  logic        wdata_ready, rdata_valid, dq_oe;
  logic [10:0] mem_addr;
  logic        ras_n, cas_n, we_n, oe_n;

  always #(CLK_PERIOD / 2) clk = ~clk;

  dram_mux_ctrl #(
    .T_RCD(T_RCD), .T_RP(T_RP), .REF_INTERVAL(REF_INTERVAL)
  ) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_we_i(req_we),
    .req_addr_i(req_addr), .req_len_i(req_len),
    .wdata_i(wdata), .wdata_ready_o(wdata_ready),
    .rdata_o(rdata), .rdata_valid_o(rdata_valid),
    .mem_addr_o(mem_addr), .mem_ras_no(ras_n), .mem_cas_no(cas_n),
    .mem_we_no(we_n), .mem_oe_no(oe_n),
    .mem_dq_o(dq_o), .mem_dq_oe_o(dq_oe), .mem_dq_i(dq_i)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done_flag = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // behavioural memory array
  logic [10:0] row_l;
  logic [3:0]  dram [int];
  logic [3:0]  shadow [int];

  function automatic logic [3:0] arr_rd(input int key);
    return dram.exists(key) ? dram[key] : 4'h0;
  endfunction

  function automatic logic [3:0] shadow_rd(input int key);
    return shadow.exists(key) ? shadow[key] : 4'h0;
  endfunction

  always @(posedge clk) begin
    if (!ras_n && cas_n) row_l <= mem_addr;
    if (!ras_n && !cas_n && !we_n) dram[int'({row_l, mem_addr})] = dq_o;
  end

  always @(negedge clk) begin
    if (!cas_n && !oe_n) dq_i <= arr_rd(int'({row_l, mem_addr}));
    else                 dq_i <= 4'h0;
  end

  // activation monitor: refresh order, refresh length, precharge gap
  int  gap = 100;
  int  act_len = 0;
  bit  act = 0, saw_cas = 0;
  logic [10:0] act_row;
  int  exp_ref_row = 0, ref_count = 0, ref_err = 0, gap_err = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!ras_n) begin
        if (!act) begin
          act = 1; saw_cas = 0; act_len = 0; act_row = mem_addr;
          if (gap < T_RP) begin
            gap_err++;
            $display("FAIL R6 precharge gap actual=%0d expected=%0d", gap, T_RP);
          end
        end
        act_len++;
        if (!cas_n) saw_cas = 1;
        gap = 0;
      end else begin
        gap++;
        if (act) begin
          act = 0;
          if (!saw_cas) begin
            if (int'(act_row) != exp_ref_row || act_len != T_RCD) begin
              ref_err++;
              $display("FAIL R7 refresh row/len actual=%0h/%0d expected=%0h/%0d",
                       act_row, act_len, exp_ref_row, T_RCD);
            end
            exp_ref_row = (exp_ref_row + 1) % 2048;
            ref_count++;
          end
        end
      end
    end
  end

  function automatic logic [3:0] beat_data(input logic [3:0] seed, input int b);
    return 4'(int'(seed) + 3 * b);
  endfunction

  // one request, checked cycle by cycle from the handshake edge
  task automatic do_burst(input bit we, input logic [10:0] row, input logic [10:0] col,
                          input logic [2:0] len, input logic [3:0] seed);
    logic [3:0] expq [8];
    int w;
    for (int b = 0; b <= int'(len); b++)
      expq[b] = shadow_rd(int'({row, 11'(int'(col) + b)}));
    req_valid = 1; req_we = we; req_addr = {row, col}; req_len = len;
    w = 0;
    while (!req_ready && w < 200) begin
      @(negedge clk);
      w++;
    end
    @(negedge clk);
    req_valid = 0;
    for (int n = 0; n < T_RCD; n++) begin
      if (n > 0) @(negedge clk);
      chk(!ras_n && cas_n && mem_addr == row && !rdata_valid, "R2 row phase",
          {ras_n, cas_n, mem_addr}, {2'b01, row});
    end
    for (int b = 0; b <= int'(len); b++) begin
      logic [10:0] ecol;
      @(negedge clk);
      ecol = 11'(int'(col) + b);
      if (we) wdata = beat_data(seed, b);
      #1;
      chk(!ras_n && !cas_n && mem_addr == ecol, "R3 column beat",
          {ras_n, cas_n, mem_addr}, {2'b00, ecol});
      if (we) begin
        chk(!we_n && oe_n && dq_oe && wdata_ready && dq_o == beat_data(seed, b),
            "R5 write beat", {we_n, oe_n, dq_oe, wdata_ready, dq_o},
            {4'b0111, beat_data(seed, b)});
        shadow[int'({row, ecol})] = beat_data(seed, b);
      end else begin
        chk(we_n && !oe_n && !dq_oe, "R4 read strobes", {we_n, oe_n, dq_oe}, 3'b100);
        if (b > 0)
          chk(rdata_valid && rdata == expq[b-1], "R4 read data",
              {rdata_valid, rdata}, {1'b1, expq[b-1]});
      end
    end
    for (int p = 0; p < T_RP; p++) begin
      @(negedge clk);
      if (p == 0 && !we)
        chk(rdata_valid && rdata == expq[len], "R4 read data last",
            {rdata_valid, rdata}, {1'b1, expq[len]});
      chk(ras_n && cas_n && we_n && oe_n && !req_ready, "R6 precharge",
          {ras_n, cas_n, we_n, oe_n, req_ready}, 5'b11110);
    end
    @(negedge clk);
    chk(ras_n && cas_n, "R6 idle after precharge", {ras_n, cas_n}, 2'b11);
  endtask

  // stimulus table: we, row, col, len, seed
  localparam logic [29:0] VECS [NVEC] = '{
    {1'b1, 11'h000, 11'h000, 3'd0, 4'h5},
    {1'b0, 11'h000, 11'h000, 3'd0, 4'h0},
    {1'b1, 11'h3A5, 11'h010, 3'd7, 4'h9},
    {1'b0, 11'h3A5, 11'h010, 3'd7, 4'h0},
    {1'b1, 11'h7FF, 11'h7FD, 3'd4, 4'h2},
    {1'b0, 11'h7FF, 11'h000, 3'd1, 4'h0},
    {1'b0, 11'h7FF, 11'h7FD, 3'd4, 4'h0},
    {1'b0, 11'h001, 11'h005, 3'd2, 4'h0},
    {1'b1, 11'h000, 11'h003, 3'd2, 4'hC},
    {1'b0, 11'h000, 11'h000, 3'd5, 4'h0}
  };

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    int w, snap, c0, delta;
    rst_n = 0; req_valid = 0; req_we = 0; req_addr = '0; req_len = '0; wdata = '0;
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(ras_n && cas_n && we_n && oe_n, "R1 strobes in reset", {ras_n, cas_n, we_n, oe_n}, 4'hF);
    rst_n = 1;
    @(negedge clk);
    chk(ras_n && cas_n && we_n && oe_n, "R1 strobes after reset", {ras_n, cas_n, we_n, oe_n}, 4'hF);
    chk(req_ready, "R1 ready after reset", req_ready, 1);
    chk(!rdata_valid, "R1 no read data", rdata_valid, 0);

    for (int i = 0; i < NVEC; i++)
      do_burst(VECS[i][29], VECS[i][28:18], VECS[i][17:7], VECS[i][6:4], VECS[i][3:0]);

    // R8: request raised while a refresh is pending goes second
    w = 0;
    while (!req_ready && w < 100) begin @(negedge clk); w++; end
    while (req_ready && w < 200) begin @(negedge clk); w++; end
    #1;
    snap = exp_ref_row;
    chk(ras_n && !req_ready, "R8 pending refresh drops ready", {ras_n, req_ready}, 2'b10);
    req_valid = 1; req_we = 0; req_addr = {11'h3A5, 11'h010}; req_len = 3'd7;
    @(negedge clk);
    chk(!ras_n && cas_n && int'(mem_addr) == snap && !req_ready, "R8 refresh served first",
        {ras_n, cas_n, mem_addr}, {2'b01, 11'(snap)});
    do_burst(1'b0, 11'h3A5, 11'h010, 3'd7, 4'h0);

    // R7: long idle, row counter wraps 2047 -> 0
    #1;
    c0 = ref_count;
    repeat (LONG_IDLE) @(negedge clk);
    #1;
    delta = ref_count - c0;
    chk(delta >= LONG_IDLE / REF_INTERVAL - 1 && delta <= LONG_IDLE / REF_INTERVAL + 1,
        "R7 refresh rate", delta, LONG_IDLE / REF_INTERVAL);
    chk(ref_count > 2048, "R7 wrap reached", ref_count, 2049);
    chk(ref_err == 0, "R7 refresh rows in order and length", ref_err, 0);
    chk(gap_err == 0, "R6 precharge gap kept", gap_err, 0);

    // data still reachable after the wrap
    do_burst(1'b0, 11'h7FF, 11'h7FD, 3'd4, 4'h0);
    finish_run();
  end
endmodule